// File: doc/BRIEF.md
# Signed Divider with Overflow Trap

This block performs signed integer division of a double-length dividend by a single-length divisor over several clock cycles. Two operand sizes are selected per operation: a narrow mode that divides a 16-bit dividend by an 8-bit divisor, and a wide mode that divides a 32-bit dividend by a 16-bit divisor. Each operation yields a single-length quotient and a single-length remainder. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.

A caller raises `start` together with the mode select and operands. The block captures them and runs a shift-subtract loop on the operand magnitudes. When the operation completes, the block pulses `ready` for one cycle. If the divisor is zero, or if the true quotient falls outside the signed range of the result, the block raises `fault` together with `ready` and leaves its result outputs unchanged. The positive limit is one less in magnitude than the negative limit, so the most negative result is accepted.

Top module: `sdiv_trap`

## Requirements
- R1: With `wide`=0, the dividend is `dividend[15:0]` and the divisor is `divisor[7:0]`, both two's complement. `dividend[31:16]` and `divisor[15:8]` have no effect. The 8-bit quotient and remainder appear sign-extended on the 16-bit `quotient` and `remainder` outputs.
- R2: With `wide`=1, the dividend is the 32-bit value `dividend[31:0]` (upper word in bits 31:16) and the divisor is `divisor[15:0]`. The 16-bit quotient and remainder are returned on `quotient` and `remainder`.
- R3: The quotient is the true quotient truncated toward zero. A nonzero remainder has the sign of the dividend, and its magnitude is smaller than the divisor's.
- R4: A zero divisor always gives `fault`=1 with the `ready` pulse.
- R5: In narrow mode, a true quotient above +127 or below -128 gives `fault`=1. Both -128 and +127 complete without fault.
- R6: In wide mode, a true quotient above +32767 or below -32768 gives `fault`=1. Both -32768 and +32767 complete without fault.
- R7: When `fault` is raised, `quotient` and `remainder` keep the values of the last operation that completed without fault.
- R8: `ready` is high for exactly one cycle per accepted operation, and `fault` is high only while `ready` is high. `ready` rises 1 cycle after the accepting clock edge when the divisor is zero or the quotient magnitude is at least 2^N. Otherwise it rises N+1 cycles after that edge. N is 8 in narrow mode and 16 in wide mode.
- R9: `start` is accepted only while `busy` is low. A `start` pulse while busy does not change the result and does not produce an extra `ready`. The operands and `wide` are sampled only at acceptance.
- R10: After reset, `busy`, `ready` and `fault` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division, taken when not busy |
| wide | input | 1 | 0: 16/8 division, 1: 32/16 division |
| dividend | input | 32 | Double-length signed dividend |
| divisor | input | 16 | Signed divisor (low byte in narrow mode) |
| busy | output | 1 | An operation is in progress |
| ready | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide error, valid with ready |
| quotient | output | 16 | Signed quotient, sign-extended in narrow mode |
| remainder | output | 16 | Signed remainder, sign-extended in narrow mode |

## Verification
The division is exercised with all four sign combinations of dividend and divisor. Results are checked against truncating reference arithmetic, which separates a correct sign fix-up from one that rounds toward minus infinity or gives the remainder the divisor's sign. Directed operands sit exactly on each mode's positive and negative quotient limits and one step beyond them. These cases separate the asymmetric limit from a symmetric one, and they separate a fault found late during sign fix-up from one caught at entry from the magnitudes. Random operands shifted arithmetically to varying magnitudes mix in-range, overflowing and zero-divisor cases, and carry junk in the unused upper bits during narrow operations. Some runs also pulse `start` while the block is busy.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
// Operand preparation: picks the mode's operand fields, takes magnitudes,
// splits the dividend into the loop's start values and flags the cases where
// the quotient magnitude is already known to reach 2^N.
module sdiv_prep #(
   parameter int HALF_W = 8
) (
   input  logic                  wide,
   input  logic [4*HALF_W-1:0]   dividend,
   input  logic [2*HALF_W-1:0]   divisor,
   output logic [2*HALF_W-1:0]   rem_init,
   output logic [2*HALF_W-1:0]   lo_init,
   output logic [2*HALF_W-1:0]   dvs_mag,
   output logic                  dvd_neg,
   output logic                  dvs_neg,
   output logic                  early_fault
);
   localparam int FULL_W = 2 * HALF_W;
   localparam int DVD_W  = 2 * FULL_W;

   logic [FULL_W-1:0] sd_b, mag_b, dvm_w;
   logic [DVD_W-1:0]  mag_w;
   logic [HALF_W-1:0] dv_b, dvm_b;

   always_comb begin
      sd_b  = dividend[FULL_W-1:0];
      mag_b = sd_b[FULL_W-1] ? -sd_b : sd_b;
      mag_w = dividend[DVD_W-1] ? -dividend : dividend;
      dv_b  = divisor[HALF_W-1:0];
      dvm_b = dv_b[HALF_W-1] ? -dv_b : dv_b;
      dvm_w = divisor[FULL_W-1] ? -divisor : divisor;
      if (wide) begin
         rem_init = mag_w[DVD_W-1:FULL_W];
         lo_init  = mag_w[FULL_W-1:0];
         dvs_mag  = dvm_w;
         dvd_neg  = dividend[DVD_W-1];
         dvs_neg  = divisor[FULL_W-1];
      end else begin
         rem_init = {{HALF_W{1'b0}}, mag_b[FULL_W-1:HALF_W]};
         lo_init  = {mag_b[HALF_W-1:0], {HALF_W{1'b0}}};
         dvs_mag  = {{HALF_W{1'b0}}, dvm_b};
         dvd_neg  = sd_b[FULL_W-1];
         dvs_neg  = dv_b[HALF_W-1];
      end
      // upper half not below divisor means quotient magnitude >= 2^N
      early_fault = (dvs_mag == '0) || (rem_init >= dvs_mag);
   end
endmodule

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
// Restoring shift-subtract loop on magnitudes, one quotient bit per step.
module sdiv_core #(
   parameter int FULL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [FULL_W-1:0] rem_init,
   input  logic [FULL_W-1:0] lo_init,
   input  logic [FULL_W-1:0] dvs_in,
   output logic [FULL_W-1:0] rem_q,
   output logic [FULL_W-1:0] lo_q
);
   logic [FULL_W-1:0] dvs_q;
   logic [FULL_W:0]   trial;
   logic [FULL_W-1:0] diff;
   logic              take;

   always_comb begin
      trial = {rem_q, lo_q[FULL_W-1]};
      take  = (trial >= {1'b0, dvs_q});
      diff  = trial[FULL_W-1:0] - dvs_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         lo_q  <= '0;
         dvs_q <= '0;
      end else if (load) begin
         rem_q <= rem_init;
         lo_q  <= lo_init;
         dvs_q <= dvs_in;
      end else if (step) begin
         rem_q <= take ? diff : trial[FULL_W-1:0];
         lo_q  <= {lo_q[FULL_W-2:0], take};
      end
   end
endmodule

// File: rtl/sdiv_fix.sv
`timescale 1ns/1ps
// Sign fix-up and asymmetric range check on the unsigned quotient magnitude.
module sdiv_fix #(
   parameter int HALF_W = 8
) (
   input  logic                wide,
   input  logic                dvd_neg,
   input  logic                dvs_neg,
   input  logic [2*HALF_W-1:0] q_mag,
   input  logic [2*HALF_W-1:0] r_mag,
   output logic [2*HALF_W-1:0] quo,
   output logic [2*HALF_W-1:0] rem,
   output logic                range_fault
);
   localparam int FULL_W = 2 * HALF_W;
   localparam logic [FULL_W-1:0] LIM_B = {{(FULL_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
   localparam logic [FULL_W-1:0] LIM_W = {1'b1, {(FULL_W-1){1'b0}}};

   logic              q_neg;
   logic [FULL_W-1:0] qsel, rsel, limit;

   always_comb begin
      q_neg = dvd_neg ^ dvs_neg;
      qsel  = wide ? q_mag : {{HALF_W{1'b0}}, q_mag[HALF_W-1:0]};
      rsel  = wide ? r_mag : {{HALF_W{1'b0}}, r_mag[HALF_W-1:0]};
      limit = wide ? LIM_W : LIM_B;
      // negative side may reach 2^(N-1), positive side only 2^(N-1)-1
      range_fault = q_neg ? (qsel > limit) : (qsel >= limit);
      quo = q_neg ? -qsel : qsel;
      rem = dvd_neg ? -rsel : rsel;
   end
endmodule

// File: rtl/sdiv_trap.sv
`timescale 1ns/1ps
module sdiv_trap #(
   parameter int HALF_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                wide,
   input  logic [4*HALF_W-1:0] dividend,
   input  logic [2*HALF_W-1:0] divisor,
   output logic                busy,
   output logic                ready,
   output logic                fault,
   output logic [2*HALF_W-1:0] quotient,
   output logic [2*HALF_W-1:0] remainder
);
   import sdiv_pkg::*;

   localparam int FULL_W = 2 * HALF_W;
   localparam int CNT_W  = $clog2(FULL_W);
   localparam logic [CNT_W-1:0] LAST_W = CNT_W'(FULL_W - 1);
   localparam logic [CNT_W-1:0] LAST_B = CNT_W'(HALF_W - 1);

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("sdiv_trap: HALF_W must be at least 2");
      end
   endgenerate

   sdiv_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic              wide_q, dn_q, sn_q, early_q;
   logic              load, step;
   logic [FULL_W-1:0] p_rem, p_lo, p_dvs, c_rem, c_lo, f_quo, f_rem;
   logic              p_dn, p_sn, p_early, f_range, any_fault;

   sdiv_prep #(.HALF_W(HALF_W)) u_prep (
      .wide(wide), .dividend(dividend), .divisor(divisor),
      .rem_init(p_rem), .lo_init(p_lo), .dvs_mag(p_dvs),
      .dvd_neg(p_dn), .dvs_neg(p_sn), .early_fault(p_early)
   );

   sdiv_core #(.FULL_W(FULL_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .rem_init(p_rem), .lo_init(p_lo), .dvs_in(p_dvs),
      .rem_q(c_rem), .lo_q(c_lo)
   );

   sdiv_fix #(.HALF_W(HALF_W)) u_fix (
      .wide(wide_q), .dvd_neg(dn_q), .dvs_neg(sn_q),
      .q_mag(c_lo), .r_mag(c_rem),
      .quo(f_quo), .rem(f_rem), .range_fault(f_range)
   );

   assign load      = (state == ST_IDLE) && start;
   assign step      = (state == ST_RUN);
   assign busy      = (state != ST_IDLE);
   assign any_fault = early_q | f_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         wide_q    <= 1'b0;
         dn_q      <= 1'b0;
         sn_q      <= 1'b0;
         early_q   <= 1'b0;
         ready     <= 1'b0;
         fault     <= 1'b0;
         quotient  <= '0;
         remainder <= '0;
      end else begin
         ready <= 1'b0;
         fault <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  wide_q  <= wide;
                  dn_q    <= p_dn;
                  sn_q    <= p_sn;
                  early_q <= p_early;
                  cnt     <= '0;
                  state   <= p_early ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               cnt <= cnt + CNT_W'(1);
               if (cnt == (wide_q ? LAST_W : LAST_B)) state <= ST_FIN;
            end
            ST_FIN: begin
               ready <= 1'b1;
               fault <= any_fault;
               if (!any_fault) begin
                  quotient  <= f_quo;
                  remainder <= f_rem;
               end
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdiv_trap_chk.sv
`timescale 1ns/1ps
module sdiv_trap_chk #(
   parameter int HALF_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                wide,
   input logic                dvd_msb_w,
   input logic                dvd_msb_b,
   input logic                dvs_msb_w,
   input logic                dvs_msb_b,
   input logic                dvs_zero_w,
   input logic                dvs_zero_b,
   input logic                busy,
   input logic                ready,
   input logic                fault,
   input logic [2*HALF_W-1:0] quotient,
   input logic [2*HALF_W-1:0] remainder
);
   localparam int FULL_W = 2 * HALF_W;

   logic cap_wide, cap_dn, cap_sn, cap_dz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_wide <= 1'b0;
         cap_dn   <= 1'b0;
         cap_sn   <= 1'b0;
         cap_dz   <= 1'b0;
      end else if (start && !busy) begin
         cap_wide <= wide;
         cap_dn   <= wide ? dvd_msb_w : dvd_msb_b;
         cap_sn   <= wide ? dvs_msb_w : dvs_msb_b;
         cap_dz   <= wide ? dvs_zero_w : dvs_zero_b;
      end
   end

   assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   assert_fault_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ready);
   assert_idle_at_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !busy);
   assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cap_dz) |-> fault);
   assert_hold_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && fault) |-> ($stable(quotient) && $stable(remainder)));
   assert_rem_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !fault && remainder != '0) |-> (remainder[FULL_W-1] == cap_dn));
   assert_quo_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !fault && quotient != '0) |-> (quotient[FULL_W-1] == (cap_dn ^ cap_sn)));
   assert_narrow_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !fault && !cap_wide) |->
         ((&quotient[FULL_W-1:HALF_W-1]) || !(|quotient[FULL_W-1:HALF_W-1])));
endmodule

bind sdiv_trap sdiv_trap_chk #(.HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
   .dvd_msb_w(dividend[4*HALF_W-1]), .dvd_msb_b(dividend[2*HALF_W-1]),
   .dvs_msb_w(divisor[2*HALF_W-1]), .dvs_msb_b(divisor[HALF_W-1]),
   .dvs_zero_w(divisor == '0), .dvs_zero_b(divisor[HALF_W-1:0] == '0),
   .busy(busy), .ready(ready), .fault(fault),
   .quotient(quotient), .remainder(remainder)
);

// File: tb/sdiv_trap_bench.sv
`timescale 1ns/1ps
module sdiv_trap_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        wide = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, ready, fault;
   logic [15:0] quotient, remainder;

   int          n_checks = 0;
   int          n_fail = 0;
   logic [15:0] last_q = '0;
   logic [15:0] last_r = '0;

   always #10 clk = ~clk;

   sdiv_trap u_sdiv_trap (
      .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
      .dividend(dividend), .divisor(divisor), .busy(busy), .ready(ready),
      .fault(fault), .quotient(quotient), .remainder(remainder)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // reference: truncating signed division with mode limits
   function automatic void model(input bit w, input logic [31:0] dvd, input logic [15:0] dvs,
                                 output bit flt, output bit early, output bit zero,
                                 output logic [15:0] q, output logic [15:0] r);
      longint a, b, qq, rr, hi, lo, big;
      if (w) begin
         a = longint'($signed(dvd)); b = longint'($signed(dvs));
         hi = 32767; lo = -32768; big = 65536;
      end else begin
         a = longint'($signed(dvd[15:0])); b = longint'($signed(dvs[7:0]));
         hi = 127; lo = -128; big = 256;
      end
      zero = (b == 0);
      q = '0; r = '0;
      if (zero) begin
         flt = 1'b1; early = 1'b1;
      end else begin
         qq = a / b; rr = a % b;
         early = (qq >= big) || (qq <= -big);
         flt = (qq > hi) || (qq < lo);
         q = 16'(qq); r = 16'(rr);
      end
   endfunction

   task automatic run_op(input bit w, input logic [31:0] dvd, input logic [15:0] dvs, input bit poke);
      bit ef, ee, ez, pk;
      logic [15:0] eq, er;
      int lat, exp_lat;
      string tq, tf;
      model(w, dvd, dvs, ef, ee, ez, eq, er);
      pk = poke && !ee;
      @(negedge clk); start = 1'b1; wide = w; dividend = dvd; divisor = dvs;
      @(posedge clk);
      @(negedge clk); start = 1'b0; wide = 1'($urandom); dividend = $urandom; divisor = 16'($urandom);
      lat = 0;
      while (!ready && lat < 100) begin
         if (pk) start = (lat == 2);
         @(posedge clk); lat++;
         @(negedge clk);
      end
      start = 1'b0;
      exp_lat = ee ? 1 : (w ? 17 : 9);
      chk("R8 latency", lat, exp_lat);
      tf = ez ? "R4 fault" : (w ? "R6 fault" : "R5 fault");
      chk(tf, 32'(fault), 32'(ef));
      if (ef) begin
         chk("R7 quotient held", quotient, last_q);
         chk("R7 remainder held", remainder, last_r);
      end else begin
         tq = w ? "R2 quotient" : "R1 quotient";
         chk(tq, quotient, eq);
         chk("R3 remainder", remainder, er);
         last_q = eq; last_r = er;
      end
      @(negedge clk);
      chk("R8 ready one cycle", 32'(ready), 32'd0);
      if (pk) begin
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R9 no extra ready", 32'(ready), 32'd0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      chk("R10 busy", 32'(busy), 32'd0);
      chk("R10 ready", 32'(ready), 32'd0);
      chk("R10 fault", 32'(fault), 32'd0);
      chk("R10 quotient", quotient, 32'd0);
      chk("R10 remainder", remainder, 32'd0);

      // narrow mode, junk in unused upper bits (R1)
      run_op(1'b0, {16'hA5A5, 16'd100},  {8'h3C, 8'd7},  1'b1);
      run_op(1'b0, {16'h5A5A, 16'hFF9C}, {8'hC3, 8'd7},  1'b0);
      run_op(1'b0, {16'h1234, 16'd100},  {8'h11, 8'hF9}, 1'b0);
      run_op(1'b0, {16'hFFFF, 16'hFF9C}, {8'hFF, 8'hF9}, 1'b0);
      run_op(1'b0, {16'h0000, 16'hFF80}, {8'h00, 8'h01}, 1'b0); // -128 ok R5
      run_op(1'b0, {16'h0000, 16'h007F}, {8'h00, 8'h01}, 1'b0); // +127 ok R5
      run_op(1'b0, {16'h0000, 16'h0080}, {8'h00, 8'h01}, 1'b0); // +128 fault R5
      run_op(1'b0, {16'h0000, 16'hFF80}, {8'h00, 8'hFF}, 1'b0); // +128 fault R5
      run_op(1'b0, {16'h0000, 16'h8000}, {8'h00, 8'h80}, 1'b0); // 256 early R5
      run_op(1'b0, {16'h0000, 16'd100},  {8'h55, 8'h00}, 1'b0); // zero R4
      run_op(1'b0, {16'h0000, 16'hFFFF}, {8'h00, 8'h02}, 1'b0); // -1/2 R3
      run_op(1'b0, {16'h0000, 16'h00FF}, {8'h00, 8'hFE}, 1'b0); // -127 r 1
      // wide mode
      run_op(1'b1, 32'd100000,   16'hFFF9, 1'b1);
      run_op(1'b1, 32'h80000000, 16'hFFFF, 1'b0); // early R6
      run_op(1'b1, 32'hFFFF8000, 16'h0001, 1'b0); // -32768 ok R6
      run_op(1'b1, 32'h00008000, 16'h0001, 1'b0); // +32768 fault R6
      run_op(1'b1, 32'hFFFF0000, 16'h0002, 1'b0); // -32768 ok R6
      run_op(1'b1, 32'h00010000, 16'h0002, 1'b0); // +32768 fault R6
      run_op(1'b1, 32'h0000FFFE, 16'h0002, 1'b0); // +32767 ok R6
      run_op(1'b1, 32'h12345678, 16'h0000, 1'b0); // zero R4
      run_op(1'b1, 32'hFFFFFFFF, 16'h0002, 1'b0); // -1/2 R3

      for (int i = 0; i < 300; i++) begin
         logic [31:0] rd, rv;
         logic [31:0] dvd;
         logic [15:0] dvs;
         bit w;
         w  = 1'($urandom);
         rd = $urandom;
         rv = $urandom;
         dvd = 32'($signed(rd) >>> $urandom_range(0, 31));
         dvs = 16'($signed(rv[15:0]) >>> $urandom_range(0, 15));
         if ($urandom_range(0, 15) == 0) dvs = '0;
         run_op(w, dvd, dvs, (i % 25) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule